// File: doc/BRIEF.md
# Divided Countdown Timer

This block is the programmable countdown timer of a local interrupt controller. Software loads a start value into the load register. Each load restarts a count-down from that value. A prescaler sets the pace: the counter drops by one once every `TICK_BASE` times the selected division factor of input clocks. When the count reaches zero, the block sends a single-cycle interrupt request that carries the vector held in the timer entry register. It then either stops at zero or reloads and keeps running, depending on a mode bit in that entry.

The division factor comes from a compact code held in the divide register. The code is built from register bit 3 as its top bit and bits 1:0 as its lower bits. The code plus one, taken modulo 8, is a shift amount, and the division factor is two to that power. Code 111 therefore divides by one and code 000 divides by two. Software can read the remaining count at any moment through the read port. Routing of the request to a processor belongs to a different block.

Top module: `tmr_top`

## Requirements
- R1: After reset every register reads zero, no interrupt is requested and the timer is idle.
- R2: The register addresses are 0 (load), 1 (remaining count), 2 (divide) and 3 (timer entry). With the 3-bit code {divide[3], divide[1:0]}, the count falls by one every TICK_BASE * 2^((code+1) mod 8) clocks. Code 111 gives a factor of 1, code 000 gives 2 and code 110 gives 128.
- R3: The divide register keeps only bits 3, 1 and 0. All other bits read back as zero.
- R4: Writing the load register stores the value and, at the same clock edge, restarts the count-down from it and restarts the prescaler.
- R5: The remaining-count register is read-only. Writes to address 1 change nothing.
- R6: When the count reaches zero, `irq` is high for exactly one cycle, unless mask bit 16 of the timer entry is set, in which case no request is made.
- R7: With entry bit 17 set (periodic), the count reloads the load value when it reaches zero and keeps running. With bit 17 clear (one-shot), it rests at zero until the next load write.
- R8: Writing zero to the load register stops the timer without an interrupt.
- R9: A divide change made while the timer runs takes effect only at the next prescaler restart, which is a load write or a periodic reload.
- R10: The timer entry register keeps the vector in bits 7:0, the mask in bit 16 and the mode in bit 17. Other bits read zero, and `irq_vector` shows the stored vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | CNT_W | Read data for rd_addr (combinational) |
| irq | output | 1 | Single-cycle interrupt request |
| irq_vector | output | 8 | Vector from the timer entry |

## Verification
The bench builds the block with CNT_W = 32 and TICK_BASE = 4. With that base, even the divide-by-128 code finishes a count of two in about a thousand clocks, so every divide code, a mid-run divide change and several periodic reloads all fit in a short run. The full 32-bit width keeps the register read-back masks and the mask and mode bit positions as they are in the default build.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W       = 2;
    localparam int VEC_W        = 8;
    localparam int MASK_BIT     = 16;
    localparam int PERIODIC_BIT = 17;

    typedef enum logic [ADDR_W-1:0] {
        REG_LOAD  = 2'd0,
        REG_LEFT  = 2'd1,
        REG_DIV   = 2'd2,
        REG_ENTRY = 2'd3
    } tmr_reg_e;
endpackage

// File: rtl/tmr_div_decode.sv
// Turns the stored 3-bit divide code into a prescaler shift amount.
module tmr_div_decode (
    input  logic [2:0] code,
    output logic [2:0] shift
);
    // Three-bit add wraps modulo 8, so code 111 yields shift 0 (divide by 1).
    assign shift = code + 3'd1;
endmodule

// File: rtl/tmr_prescaler.sv
// Counts input clocks and emits one tick per (TICK_BASE << shift) clocks.
module tmr_prescaler #(
    parameter int TICK_BASE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       relatch,
    input  logic       run,
    input  logic [2:0] shift_in,
    output logic       tick
);
    localparam int MAX_LEN = TICK_BASE * 128;
    localparam int PW      = $clog2(MAX_LEN) + 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic [2:0]    shift;
    } pre_t;

    pre_t pr_d, pr_q;
    logic [PW-1:0] last_d;

    assign last_d = (PW'(TICK_BASE) << pr_q.shift) - PW'(1);
    assign tick   = run && !start && (pr_q.cnt == last_d);

    always_comb begin
        pr_d = pr_q;
        if (start) begin
            pr_d.cnt   = '0;
            pr_d.shift = shift_in;
        end else if (run) begin
            pr_d.cnt = tick ? '0 : pr_q.cnt + PW'(1);
            if (relatch) pr_d.shift = shift_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pr_q <= '0;
        else        pr_q <= pr_d;
    end
endmodule

// File: rtl/tmr_top.sv
module tmr_top
    import tmr_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int TICK_BASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [1:0]        rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq,
    output logic [7:0]        irq_vector
);
    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] left;
        logic [2:0]       code;
        logic [VEC_W-1:0] vec;
        logic             mask;
        logic             periodic;
        logic             running;
        logic             irq;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       load_wr;
    logic       tick;
    logic       reload;
    logic [2:0] shift;

    // Aliases for the bound checker.
    logic [CNT_W-1:0] left_now;
    logic [CNT_W-1:0] load_now;
    logic             mask_now;
    logic             periodic_now;
    assign left_now     = st_q.left;
    assign load_now     = st_q.load;
    assign mask_now     = st_q.mask;
    assign periodic_now = st_q.periodic;

    assign load_wr = wr_en && (tmr_reg_e'(wr_addr) == REG_LOAD);

    tmr_div_decode u_dec (
        .code  (st_q.code),
        .shift (shift)
    );

    tmr_prescaler #(.TICK_BASE(TICK_BASE)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (load_wr),
        .relatch  (reload),
        .run      (st_q.running),
        .shift_in (shift),
        .tick     (tick)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        reload   = 1'b0;
        // Countdown step; a load write in the same cycle takes precedence.
        if (st_q.running && tick && !load_wr) begin
            if (st_q.left == CNT_W'(1)) begin
                st_d.irq = !st_q.mask;
                if (st_q.periodic) begin
                    st_d.left = st_q.load;
                    reload    = 1'b1;
                end else begin
                    st_d.left    = '0;
                    st_d.running = 1'b0;
                end
            end else begin
                st_d.left = st_q.left - CNT_W'(1);
            end
        end
        if (wr_en) begin
            case (tmr_reg_e'(wr_addr))
                REG_LOAD: begin
                    st_d.load    = wr_data;
                    st_d.left    = wr_data;
                    st_d.running = (wr_data != '0);
                end
                REG_DIV:   st_d.code = {wr_data[3], wr_data[1:0]};
                REG_ENTRY: begin
                    st_d.vec      = wr_data[VEC_W-1:0];
                    st_d.mask     = wr_data[MASK_BIT];
                    st_d.periodic = wr_data[PERIODIC_BIT];
                end
                default: ; // remaining count is read-only
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (tmr_reg_e'(rd_addr))
            REG_LOAD:  rd_data = st_q.load;
            REG_LEFT:  rd_data = st_q.left;
            REG_DIV:   rd_data = CNT_W'({st_q.code[2], 1'b0, st_q.code[1:0]});
            REG_ENTRY: begin
                rd_data[VEC_W-1:0]   = st_q.vec;
                rd_data[MASK_BIT]     = st_q.mask;
                rd_data[PERIODIC_BIT] = st_q.periodic;
            end
            default: rd_data = '0;
        endcase
    end

    assign irq        = st_q.irq;
    assign irq_vector = st_q.vec;
endmodule

// File: rtl/tmr_top_chk.sv
module tmr_top_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             irq,
    input logic [CNT_W-1:0] left_now,
    input logic [CNT_W-1:0] load_now,
    input logic             mask_now,
    input logic             periodic_now
);
    a_r4_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_addr == 2'd0) |-> left_now == $past(wr_data));

    a_r8_zero_load_stops: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_addr == 2'd0 && wr_data == '0) |-> (left_now == '0 && !irq));

    a_r6_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(mask_now));

    a_r7_oneshot_rests_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(periodic_now)) |-> left_now == '0);

    a_r2_count_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (left_now != $past(left_now)) |->
            (left_now == $past(left_now) - CNT_W'(1)) ||
            $past(wr_en && wr_addr == 2'd0) ||
            (left_now == load_now));
endmodule

bind tmr_top tmr_top_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .irq          (irq),
    .left_now     (left_now),
    .load_now     (load_now),
    .mask_now     (mask_now),
    .periodic_now (periodic_now)
);

// File: tb/tmr_top_tb.sv
module tmr_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = CLK_PERIOD / 4;
    localparam int CNT_W      = 32;
    localparam int TICK_BASE  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [1:0]       rd_addr = 2'd1;
    logic [CNT_W-1:0] rd_data;
    logic             irq;
    logic [7:0]       irq_vector;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    int cycles = 0;
    string phase = "R1";

    // reference model state
    logic [31:0] m_load = 0, m_left = 0;
    logic [2:0]  m_code = 0;
    logic [7:0]  m_vec = 0;
    bit          m_mask = 0, m_per = 0, m_run = 0, m_irq = 0;
    int          m_togo = 0, m_len = 0;

    tmr_top #(.CNT_W(CNT_W), .TICK_BASE(TICK_BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .irq_vector(irq_vector));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int period_of(logic [2:0] c);
        return TICK_BASE * (1 << ((int'(c) + 1) % 8));
    endfunction

    function automatic logic [31:0] model_read(logic [1:0] a);
        case (a)
            2'd0: return m_load;
            2'd1: return m_left;
            2'd2: return {28'd0, m_code[2], 1'b0, m_code[1:0]};
            default: return {14'd0, m_per, m_mask, 8'd0, m_vec};
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // model update at each edge, then compare a quarter period later
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_load = 0; m_left = 0; m_code = 0; m_vec = 0;
            m_mask = 0; m_per = 0; m_run = 0; m_irq = 0; m_togo = 0; m_len = 0;
        end else begin
            m_irq = 0;
            if (m_run && !(wr_en && wr_addr == 2'd0)) begin
                m_togo = m_togo - 1;
                if (m_togo == 0) begin
                    if (m_left == 1) begin
                        m_irq = !m_mask;
                        if (m_per) begin
                            m_left = m_load;
                            m_len  = period_of(m_code);
                        end else begin
                            m_left = 0;
                            m_run  = 0;
                        end
                    end else begin
                        m_left = m_left - 1;
                    end
                    m_togo = m_len;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin
                        m_load = wr_data; m_left = wr_data; m_run = (wr_data != 0);
                        m_len = period_of(m_code); m_togo = m_len;
                    end
                    2'd2: m_code = {wr_data[3], wr_data[1:0]};
                    2'd3: begin
                        m_vec = wr_data[7:0]; m_mask = wr_data[16]; m_per = wr_data[17];
                    end
                    default: ;
                endcase
            end
        end
        #(QTR);
        check({phase, " rd_data"}, rd_data, model_read(rd_addr));
        check({phase, " irq"}, {31'd0, irq}, {31'd0, m_irq});
        check({phase, " irq_vector"}, {24'd0, irq_vector}, {24'd0, m_vec});
        if (irq) irq_seen++;
    end

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        phase = "R1";
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v); check("R1 reset read", v, 32'd0);
        end
        check("R1 irq idle", {31'd0, irq}, 32'd0);
        rd_addr = 2'd1;
        // R3 divide register keeps bits 3,1,0
        phase = "R3";
        wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); check("R3 div mask", v, 32'h0000_000B);
        wr(2'd2, 32'h0000_00F4); rd(2'd2, v); check("R3 div cleared", v, 32'd0);
        // R10 timer entry fields
        phase = "R10";
        wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); check("R10 entry mask", v, 32'h0003_00FF);
        check("R10 vector out", {24'd0, irq_vector}, 32'h0000_00FF);
        wr(2'd3, 32'h0000_0042);
        // R2 divide codes, R6 single pulse, R7 one-shot rest
        phase = "R2";
        wr(2'd2, 32'hB); irq_seen = 0; wr(2'd0, 3); idle(3*4 + 4);
        check("R2 div1 irq count", irq_seen, 1);
        rd(2'd1, v); check("R7 one-shot stays zero", v, 0);
        wr(2'd2, 32'h0); irq_seen = 0; wr(2'd0, 2); idle(2*8 + 4);
        check("R2 div2 irq count", irq_seen, 1);
        wr(2'd2, 32'hA); irq_seen = 0; wr(2'd0, 2); idle(5);
        rd(2'd1, v); check("R2 div128 still counting", v, 2);
        idle(2*512);
        check("R6 div128 single pulse", irq_seen, 1);
        // R5 read-only remaining count
        phase = "R5";
        wr(2'd2, 32'hB); wr(2'd0, 20); idle(10);
        wr(2'd1, 32'h0000_1234);
        rd(2'd1, v); check("R5 left unchanged", v, m_left);
        rd(2'd0, v); check("R5 load unchanged", v, 20);
        // R4 mid-run restart
        phase = "R4";
        wr(2'd0, 7); rd(2'd1, v); check("R4 restart value", v, 7);
        idle(3); rd(2'd1, v); check("R4 first step timing", v, 6);
        // R9 divide change mid-run
        phase = "R9";
        wr(2'd3, 32'h0002_0042); wr(2'd0, 3); idle(2);
        wr(2'd2, 32'h1); irq_seen = 0; idle(10);
        check("R9 old rate holds", irq_seen, 1);
        idle(3*16 + 2);
        check("R9 new rate after reload", irq_seen, 2);
        // R7 periodic
        phase = "R7";
        wr(2'd2, 32'hB); irq_seen = 0; wr(2'd0, 2); idle(26);
        check("R7 periodic pulses", irq_seen, 3);
        rd(2'd0, v); check("R7 load kept", v, 2);
        // R8 zero load stops
        phase = "R8";
        wr(2'd0, 0); irq_seen = 0; idle(20);
        check("R8 no irq", irq_seen, 0);
        rd(2'd1, v); check("R8 left zero", v, 0);
        // R6 mask suppresses request
        phase = "R6";
        wr(2'd3, 32'h0001_0042); irq_seen = 0; wr(2'd0, 2); idle(20);
        check("R6 masked no irq", irq_seen, 0);
        rd(2'd1, v); check("R6 masked reaches zero", v, 0);
        idle(2);
        finish_run();
    end
endmodule